// File: doc/BRIEF.md
# Dual-Width Register Access Bridge

This block connects a host bus that moves 32-bit words to a bank of 32-bit internal registers. The host sees twice as many word addresses as there are registers. Out of reset the bridge works in narrow mode. In that mode each host address reaches one 16-bit half of a register: the low address bit selects the upper or lower half, and the remaining bits select the register. A mode bit held in a master control register switches the bridge to wide mode. In wide mode an even host address reaches a whole register.

Narrow writes merge the new half into the register and leave the other half untouched. Narrow reads return the selected half, zero-extended to 32 bits. Read data comes back one cycle after the request and is marked by a valid strobe. The master control register lives in the same bank as the other registers, so the host changes modes with an ordinary register write. The new mode applies from the very next access.

Top module: `dual_width_reg_bridge`

## Requirements
- R1: After reset every register holds zero, the bridge is in narrow mode (`wide_mode_o` = 0) and `rvalid_o` is 0.
- R2: In narrow mode, a write to an odd host address `a` stores `wdata_i[15:0]` into bits 31:16 of register `a>>1`. Bits 15:0 of that register keep their value.
- R3: In narrow mode, a write to an even host address `a` stores `wdata_i[15:0]` into bits 15:0 of register `a>>1`. Bits 31:16 of that register keep their value.
- R4: In narrow mode, a read returns `{16'h0000, half}`, where `half` is bits 31:16 of register `a>>1` for an odd address and bits 15:0 for an even address.
- R5: In wide mode, a write to an even host address stores all 32 bits of `wdata_i` into register `a>>1`.
- R6: In wide mode, a read from an even host address returns the full 32-bit register `a>>1`.
- R7: In wide mode, a write to an odd host address changes no register.
- R8: In wide mode, a read from an odd host address returns `{16'h0000, bits 31:16 of register a>>1}`.
- R9: Bit 17 of register 64 (host address 0x080 in wide mode; bit 1 of the data written to host address 0x081 in narrow mode) selects narrow (0) or wide (1) mode. `wide_mode_o` shows this bit. A request in the cycle right after the write that changes it already uses the new mode.
- R10: `rvalid_o` is 1 for exactly one cycle, the cycle after a read request, with `rdata_o` valid in that cycle. A write request never raises `rvalid_o`.
- R11: In narrow mode, `wdata_i[31:16]` has no effect on any register.
- R12: Each of the 512 registers is separate storage. Writing register 511 (addresses 0x3FE/0x3FF) leaves register 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_i | input | 1 | Host access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Host word address |
| wdata_i | input | 32 | Host write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |
| wide_mode_o | output | 1 | Current mode, 1 = wide |

## Verification
The bench builds the bridge with its default parameters: a 10-bit host address, 512 registers, the control register at host address 0x080, and bit 17 as the mode bit. With these values the top register at 0x3FE/0x3FF can be checked against register 0. They also place the mode bit at bit 1 of the upper half, which exercises the mode switch through a narrow write to 0x081. The bench also drives a mode-changing write followed at once by a read. This shows that the new mode applies with no idle cycle in between.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int unsigned RB_HOST_AW   = 10;
  localparam int unsigned RB_DATA_W    = 32;
  localparam int unsigned RB_CTRL_ADDR = 'h080;
  localparam int unsigned RB_MODE_BIT  = 17;

  // How the registered read word is shaped on its way to the host.
  typedef struct packed {
    logic narrow;  // return only one half, zero-extended
    logic upper;   // the half returned is bits [DATA_W-1:HALF_W]
  } rd_fmt_t;
endpackage

// File: rtl/rb_addr_decode.sv
module rb_addr_decode
  import rb_pkg::*;
#(
  parameter int unsigned HOST_AW = RB_HOST_AW,
  parameter int unsigned DATA_W  = RB_DATA_W,
  localparam int unsigned IDX_W  = HOST_AW - 1,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wr_lo_en_o,
  output logic              wr_hi_en_o,
  output logic [DATA_W-1:0] wr_word_o,
  output logic              rd_en_o,
  output rd_fmt_t           rd_fmt_o
);
  function automatic logic [IDX_W-1:0] reg_index(input logic [HOST_AW-1:0] a);
    return a[HOST_AW-1:1];
  endfunction

  function automatic logic half_is_upper(input logic [HOST_AW-1:0] a);
    return a[0];
  endfunction

  // Narrow data is replicated into both halves; the enables pick one.
  function automatic logic [DATA_W-1:0] spread_half(input logic [DATA_W-1:0] d);
    return {d[HALF_W-1:0], d[HALF_W-1:0]};
  endfunction

  logic wr_req;
  logic odd_addr;

  assign wr_req   = req_i && we_i;
  assign odd_addr = half_is_upper(addr_i);
  assign idx_o    = reg_index(addr_i);
  assign rd_en_o  = req_i && !we_i;

  always_comb begin
    wr_lo_en_o = 1'b0;
    wr_hi_en_o = 1'b0;
    wr_word_o  = wdata_i;
    if (wr_req) begin
      if (mode_wide_i) begin
        wr_lo_en_o = !odd_addr;
        wr_hi_en_o = !odd_addr;
      end else begin
        wr_word_o  = spread_half(wdata_i);
        wr_lo_en_o = !odd_addr;
        wr_hi_en_o = odd_addr;
      end
    end
  end

  always_comb begin
    rd_fmt_o.upper  = odd_addr;
    rd_fmt_o.narrow = !mode_wide_i || odd_addr;
  end

  // R7
  wide_odd_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && mode_wide_i && addr_i[0]) |-> (!wr_lo_en_o && !wr_hi_en_o));

  // R2
  narrow_one_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && !mode_wide_i) |-> ($countones({wr_hi_en_o, wr_lo_en_o}) == 1));

  // R10
  no_wr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i) |-> !rd_en_o);
endmodule

// File: rtl/rb_reg_store.sv
module rb_reg_store
  import rb_pkg::*;
#(
  parameter int unsigned NREG     = 512,
  parameter int unsigned DATA_W   = RB_DATA_W,
  parameter int unsigned CTRL_IDX = RB_CTRL_ADDR / 2,
  parameter int unsigned MODE_BIT = RB_MODE_BIT,
  localparam int unsigned IDX_W   = $clog2(NREG),
  localparam int unsigned HALF_W  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_lo_en_i,
  input  logic              wr_hi_en_i,
  input  logic [DATA_W-1:0] wr_word_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic              rd_valid_o,
  output logic              mode_wide_o
);
  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (wr_lo_en_i) regs[idx_i][HALF_W-1:0]      <= wr_word_i[HALF_W-1:0];
      if (wr_hi_en_i) regs[idx_i][DATA_W-1:HALF_W] <= wr_word_i[DATA_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_word_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_word_o <= regs[idx_i];
    end
  end

  assign mode_wide_o = regs[CTRL_IDX][MODE_BIT];

  // Observation points for the half-merge properties.
  logic [IDX_W-1:0]  last_wr_idx_q;
  logic [DATA_W-1:0] row_before;
  logic [DATA_W-1:0] row_after;

  always_ff @(posedge clk) begin
    if (!rst_n) last_wr_idx_q <= '0;
    else if (wr_lo_en_i || wr_hi_en_i) last_wr_idx_q <= idx_i;
  end

  assign row_before = regs[idx_i];
  assign row_after  = regs[last_wr_idx_q];

  // R3
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_en_i && !wr_hi_en_i) |=>
      (row_after[DATA_W-1:HALF_W] == $past(row_before[DATA_W-1:HALF_W])));

  // R2
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_en_i && !wr_lo_en_i) |=>
      (row_after[HALF_W-1:0] == $past(row_before[HALF_W-1:0])));

  // R5
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_en_i && wr_lo_en_i) |=> (row_after == $past(wr_word_i)));
endmodule

// File: rtl/rb_read_format.sv
module rb_read_format
  import rb_pkg::*;
#(
  parameter int unsigned DATA_W = RB_DATA_W,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  rd_fmt_t           fmt_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o
);
  function automatic logic [DATA_W-1:0] shape(input rd_fmt_t f, input logic [DATA_W-1:0] w);
    logic [HALF_W-1:0] h;
    h = f.upper ? w[DATA_W-1:HALF_W] : w[HALF_W-1:0];
    return f.narrow ? {{HALF_W{1'b0}}, h} : w;
  endfunction

  assign data_o = shape(fmt_i, word_i);
endmodule

// File: rtl/dual_width_reg_bridge.sv
module dual_width_reg_bridge
  import rb_pkg::*;
#(
  parameter int unsigned HOST_AW   = RB_HOST_AW,
  parameter int unsigned DATA_W    = RB_DATA_W,
  parameter int unsigned CTRL_ADDR = RB_CTRL_ADDR,
  parameter int unsigned MODE_BIT  = RB_MODE_BIT,
  localparam int unsigned NREG     = 2 ** (HOST_AW - 1),
  localparam int unsigned IDX_W    = HOST_AW - 1,
  localparam int unsigned HALF_W   = DATA_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               rvalid_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               wide_mode_o
);
  logic [IDX_W-1:0]  idx;
  logic              wr_lo_en;
  logic              wr_hi_en;
  logic [DATA_W-1:0] wr_word;
  logic              rd_en;
  rd_fmt_t           rd_fmt;
  rd_fmt_t           rd_fmt_q;
  logic [DATA_W-1:0] rd_word;
  logic              mode_wide;

  rb_addr_decode #(.HOST_AW(HOST_AW), .DATA_W(DATA_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wide_i(mode_wide),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .idx_o      (idx),
    .wr_lo_en_o (wr_lo_en),
    .wr_hi_en_o (wr_hi_en),
    .wr_word_o  (wr_word),
    .rd_en_o    (rd_en),
    .rd_fmt_o   (rd_fmt)
  );

  rb_reg_store #(
    .NREG    (NREG),
    .DATA_W  (DATA_W),
    .CTRL_IDX(CTRL_ADDR / 2),
    .MODE_BIT(MODE_BIT)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_i      (idx),
    .wr_lo_en_i (wr_lo_en),
    .wr_hi_en_i (wr_hi_en),
    .wr_word_i  (wr_word),
    .rd_en_i    (rd_en),
    .rd_word_o  (rd_word),
    .rd_valid_o (rvalid_o),
    .mode_wide_o(mode_wide)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_fmt_q <= '0;
    else if (rd_en) rd_fmt_q <= rd_fmt;
  end

  rb_read_format #(.DATA_W(DATA_W)) u_format (
    .fmt_i (rd_fmt_q),
    .word_i(rd_word),
    .data_o(rdata_o)
  );

  assign wide_mode_o = mode_wide;

  // R10
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i) |=> rvalid_o);

  // R10
  rd_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && !we_i) |=> !rvalid_o);

  // R4
  narrow_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && !wide_mode_o) |=> (rdata_o[DATA_W-1:HALF_W] == '0));

  // R8
  wide_odd_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && wide_mode_o && addr_i[0]) |=> (rdata_o[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/dual_width_reg_bridge_bench.sv
module dual_width_reg_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [9:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        rvalid_o;
  logic [31:0] rdata_o;
  logic        wide_mode_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] shadow [512];
  bit          shadow_wide = 1'b0;

  always #10 clk = ~clk;

  dual_width_reg_bridge u_dual_width_reg_bridge (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rvalid_o   (rvalid_o),
    .rdata_o    (rdata_o),
    .wide_mode_o(wide_mode_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Bench-side rules for what a write does.
  function automatic void model_write(input logic [9:0] a, input logic [31:0] d);
    int r;
    r = int'(a >> 1);
    if (shadow_wide) begin
      if (!a[0]) shadow[r] = d;
    end else if (a[0]) begin
      shadow[r][31:16] = d[15:0];
    end else begin
      shadow[r][15:0] = d[15:0];
    end
    shadow_wide = shadow[64][17];
  endfunction

  function automatic logic [31:0] model_read(input logic [9:0] a);
    logic [31:0] w;
    w = shadow[int'(a >> 1)];
    if (shadow_wide && !a[0]) return w;
    return a[0] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  task automatic host_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    model_write(a, d);
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
    check("R10 no rvalid after write", {31'b0, rvalid_o}, 32'h0);
  endtask

  task automatic host_read(input logic [9:0] a, input string tag);
    logic [31:0] exp;
    exp = model_read(a);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk);
    req_i = 1'b0;
    check("R10 rvalid one cycle after read", {31'b0, rvalid_o}, 32'h1);
    check(tag, rdata_o, exp);
    @(negedge clk);
    check("R10 rvalid drops", {31'b0, rvalid_o}, 32'h0);
  endtask

  task automatic t_reset;
    check("R1 narrow after reset", {31'b0, wide_mode_o}, 32'h0);
    check("R1 rvalid low after reset", {31'b0, rvalid_o}, 32'h0);
    host_read(10'h000, "R1 reg0 low zero");
    host_read(10'h3FF, "R1 reg511 high zero");
    host_read(10'h081, "R1 ctrl high zero");
  endtask

  task automatic t_narrow_halves;
    host_write(10'h011, 32'hABCD_1234);
    host_write(10'h010, 32'hFFFF_5678);
    host_read(10'h011, "R2 upper half");
    host_read(10'h010, "R3 R4 lower half");
    host_write(10'h011, 32'h0000_9999);
    host_read(10'h010, "R2 lower kept");
    host_write(10'h010, 32'h5555_4321);
    host_read(10'h011, "R3 R11 upper kept");
  endtask

  task automatic t_distinct;
    host_write(10'h3FE, 32'h0000_AAAA);
    host_write(10'h3FF, 32'h0000_BBBB);
    host_read(10'h3FF, "R12 reg511 upper");
    host_read(10'h3FE, "R12 reg511 lower");
    host_read(10'h000, "R12 reg0 untouched");
    host_read(10'h001, "R12 reg0 upper untouched");
  endtask

  // Narrow write sets bit 17, then a read follows in the very next cycle.
  task automatic t_mode_switch_b2b;
    logic [31:0] exp;
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 10'h081; wdata_i = 32'hFFFF_0002;
    model_write(10'h081, 32'hFFFF_0002);
    @(negedge clk);
    we_i = 1'b0; addr_i = 10'h010;
    exp = model_read(10'h010);
    @(negedge clk);
    req_i = 1'b0;
    check("R9 wide_mode_o set", {31'b0, wide_mode_o}, 32'h1);
    check("R9 next access wide", rdata_o, exp);
    check("R9 expected full word", exp, 32'h9999_4321);
    @(negedge clk);
  endtask

  task automatic t_wide;
    host_write(10'h020, 32'hDEAD_BEEF);
    host_read(10'h020, "R5 R6 full word");
    host_read(10'h021, "R8 odd read upper");
    host_write(10'h021, 32'h1234_5678);
    host_read(10'h020, "R7 odd write ignored");
    host_read(10'h021, "R7 odd write ignored upper");
    host_read(10'h080, "R6 ctrl full");
  endtask

  task automatic t_back_to_narrow;
    host_write(10'h080, 32'h0000_0000);
    check("R9 back to narrow", {31'b0, wide_mode_o}, 32'h0);
    host_read(10'h020, "R4 narrow lower after switch");
    host_read(10'h021, "R4 narrow upper after switch");
  endtask

  initial begin
    for (int i = 0; i < 512; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow_halves();
    t_distinct();
    t_mode_switch_b2b();
    t_wide();
    t_back_to_narrow();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule